// File: doc/BRIEF.md
# Regulator Output Fault and Power-Good Supervisor

This block watches one switching-regulator output through four digitized window-comparator flags: output more than 10 % above its target, output more than 10 % below its target, output at or above 90 % of its target, and output more than 30 % below its target. It also takes a soft-start-complete input and a channel enable. From these it produces a power-good indication and two latched fault requests. The overvoltage request asks the power stage to hold the low-side switch on. The undervoltage request asks the power stage to float its output.

Each condition passes through a deglitch filter before it has any effect. The filter is a consecutive-cycle counter whose length is a parameter, sized to about 5 µs of the system clock. A fault, once latched, turns the channel off. The only way to clear it is to drive the channel enable low and then high again. A system with two regulated rails uses one instance per rail, and a fault in one instance has no effect on the other.

Top module: `outmon_supervisor`

## Requirements
- R1: `pg_ok` rises only after the good condition has been sampled true on HOLD_CYC consecutive rising clock edges, counting from the first edge that sees it. The good condition is `ss_done`=1, `at_ninety`=1, `over_hi`=0 and `under_lo`=0. `pg_ok` falls after the good condition has been false on HOLD_CYC consecutive edges.
- R2: `pg_ok` stays 0 while `ss_done` is 0, even when the output is within the window and above 90 %.
- R3: A condition that lasts fewer than HOLD_CYC consecutive edges changes no output. Each filter counter restarts from zero whenever its condition drops out.
- R4: `over_hi` held for HOLD_CYC edges sets `crowbar_req` on the following edge. It then stays set while `chan_en` is 1, whatever the comparator inputs do.
- R5: `deep_under` held together with `ss_done` for HOLD_CYC edges sets `tristate_req` on the following edge. It then stays set while `chan_en` is 1.
- R6: `deep_under` has no effect while `ss_done` is 0.
- R7: `chan_en`=0 clears both fault latches on the next edge, restarts all filters and holds `pg_ok` at 0.
- R8: If both faults qualify on the same edge, only `crowbar_req` is set. While one fault is latched, the other is never set.
- R9: `pg_ok` is 0 whenever either fault request is 1.
- R10: While `rst_n` is 0, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable; driving it low clears latched faults |
| ss_done | input | 1 | Soft-start ramp finished |
| over_hi | input | 1 | Output more than 10 % above target |
| under_lo | input | 1 | Output more than 10 % below target |
| at_ninety | input | 1 | Output at or above 90 % of target |
| deep_under | input | 1 | Output more than 30 % below target |
| pg_ok | output | 1 | Power good, active high; an open-drain pad pulls low when 0 |
| crowbar_req | output | 1 | Latched overvoltage: hold the low-side switch on |
| tristate_req | output | 1 | Latched undervoltage: float the power stage |

## Verification
The assertions check every cycle that a fault, once latched, is held while the channel is enabled. They also check that clearing through the enable removes all three outputs, that `pg_ok` never coexists with a fault request, and that every rise of an output is preceded by its qualifying input. Only the bench scenarios can show the exact HOLD_CYC-edge timing, the restart of a counter after a pulse one edge short, the masking of undervoltage before soft start, and overvoltage winning when both faults qualify together.

// File: rtl/outmon_pkg.sv
`timescale 1ns/1ps
package outmon_pkg;
    // Deglitched condition slots
    localparam int NUM_COND = 3;
    localparam int COND_PG  = 0;
    localparam int COND_OV  = 1;
    localparam int COND_UV  = 2;

    // Latched fault kind; one encoding keeps the two faults exclusive (R8)
    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_OVER  = 2'd1,
        FLT_UNDER = 2'd2
    } fault_kind_e;

    typedef struct packed {
        fault_kind_e kind;
    } latch_state_t;
endpackage

// File: rtl/outmon_deglitch.sv
`timescale 1ns/1ps
// Level filter: output follows raw only after raw differs from it on
// HOLD_CYC consecutive edges (R1, R3).
module outmon_deglitch #(
    parameter int unsigned HOLD_CYC = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw,
    output logic filt
);
    localparam int unsigned CW = (HOLD_CYC > 2) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } dg_state_t;

    dg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (raw == st_q.lvl) begin
            st_d.cnt = '0;                 // condition dropped out: restart
        end else if (st_q.cnt == LAST) begin
            st_d.lvl = raw;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign filt = st_q.lvl;
endmodule

// File: rtl/outmon_fault_latch.sv
`timescale 1ns/1ps
// Holds the first qualified fault until the channel is disabled (R4, R5, R7, R8).
module outmon_fault_latch
    import outmon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        ov_qual,
    input  logic        uv_qual,
    output fault_kind_e kind
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!arm) begin
            st_d.kind = FLT_NONE;
        end else if (st_q.kind == FLT_NONE) begin
            if (ov_qual)      st_d.kind = FLT_OVER;   // overvoltage wins ties
            else if (uv_qual) st_d.kind = FLT_UNDER;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{kind: FLT_NONE};
        else        st_q <= st_d;
    end

    assign kind = st_q.kind;
endmodule

// File: rtl/outmon_supervisor.sv
`timescale 1ns/1ps
module outmon_supervisor
    import outmon_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 625   // about 5 us at 125 MHz
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chan_en,
    input  logic ss_done,
    input  logic over_hi,
    input  logic under_lo,
    input  logic at_ninety,
    input  logic deep_under,
    output logic pg_ok,
    output logic crowbar_req,
    output logic tristate_req
);
    logic [NUM_COND-1:0] raw;
    logic [NUM_COND-1:0] filt;
    fault_kind_e         kind;

    always_comb begin
        raw           = '0;
        raw[COND_PG]  = ss_done & at_ninety & ~over_hi & ~under_lo; // R1, R2
        raw[COND_OV]  = over_hi;                                     // R4
        raw[COND_UV]  = deep_under & ss_done;                        // R5, R6
    end

    for (genvar g = 0; g < NUM_COND; g++) begin : g_dg
        outmon_deglitch #(.HOLD_CYC(HOLD_CYC)) u_dg (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (~chan_en),
            .raw   (raw[g]),
            .filt  (filt[g])
        );
    end

    outmon_fault_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (chan_en),
        .ov_qual (filt[COND_OV]),
        .uv_qual (filt[COND_UV]),
        .kind    (kind)
    );

    assign crowbar_req  = (kind == FLT_OVER);
    assign tristate_req = (kind == FLT_UNDER);
    assign pg_ok        = filt[COND_PG] & chan_en & (kind == FLT_NONE); // R9
endmodule

// File: rtl/outmon_supervisor_chk.sv
`timescale 1ns/1ps
module outmon_supervisor_chk (
    input logic clk,
    input logic rst_n,
    input logic chan_en,
    input logic ss_done,
    input logic over_hi,
    input logic under_lo,
    input logic at_ninety,
    input logic deep_under,
    input logic pg_ok,
    input logic crowbar_req,
    input logic tristate_req
);
    assert_pg_rise_needs_good_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_ok) |-> $past(ss_done && at_ninety && !over_hi && !under_lo));

    assert_ov_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (crowbar_req && chan_en) |=> crowbar_req);

    assert_ov_needs_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crowbar_req) |-> $past(over_hi));

    assert_uv_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tristate_req && chan_en) |=> tristate_req);

    assert_uv_needs_softstart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tristate_req) |-> $past(ss_done && deep_under));

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (!crowbar_req && !tristate_req && !pg_ok));

    assert_pg_low_on_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (crowbar_req || tristate_req) |-> !pg_ok);
endmodule

bind outmon_supervisor outmon_supervisor_chk u_chk (.*);

// File: tb/tb_outmon_supervisor.sv
`timescale 1ns/1ps
module tb_outmon_supervisor;
    localparam int unsigned N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chan_en = 1'b0, ss_done = 1'b0, over_hi = 1'b0, under_lo = 1'b0;
    logic at_ninety = 1'b0, deep_under = 1'b0;
    logic pg_ok, crowbar_req, tristate_req;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    outmon_supervisor #(.HOLD_CYC(N)) dut (.*);

    typedef struct packed {
        logic       en, ss, a90, ovh, unl, deep;
        logic [7:0] hold;
        logic       pg, ov, uv;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        //  en   ss   a90  ovh  unl  deep  hold       pg   ov   uv   req
        '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 8'(N+4), 1'b0,1'b0,1'b0, 4'd2},  // R2 no soft start
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'(N-1), 1'b0,1'b0,1'b0, 4'd1},  // R1 one edge short
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd1,    1'b1,1'b0,1'b0, 4'd1},  // R1 reaches N
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 8'(N-1), 1'b1,1'b0,1'b0, 4'd3},  // R3 short dip
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd2,    1'b1,1'b0,1'b0, 4'd3},  // R3 restart
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 8'(N),   1'b0,1'b0,1'b0, 4'd1},  // R1 falls
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'(N),   1'b1,1'b0,1'b0, 4'd1},  // R1 recovers
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'(N-1), 1'b1,1'b0,1'b0, 4'd3},  // R3 short OV
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd3,    1'b1,1'b0,1'b0, 4'd3},  // R3 no effect
        '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 8'(N+1), 1'b0,1'b1,1'b0, 4'd4},  // R4 OV latches
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'(N+4), 1'b0,1'b1,1'b0, 4'd9},  // R4 R9 held, pg low
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd1,    1'b0,1'b0,1'b0, 4'd7},  // R7 clear
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'(N),   1'b1,1'b0,1'b0, 4'd7},  // R7 restart ok
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 8'(N+1), 1'b0,1'b0,1'b1, 4'd5},  // R5 UV latches
        '{1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 8'(N+4), 1'b0,1'b0,1'b1, 4'd9},  // R5 R9 held
        '{1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 8'd1,    1'b0,1'b0,1'b0, 4'd7},  // R7 clear
        '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 8'(N+4), 1'b0,1'b0,1'b0, 4'd6},  // R6 masked
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 8'(N-1), 1'b0,1'b0,1'b0, 4'd6},  // R6 counts from ss
        '{1'b1,1'b1,1'b0,1'b0,1'b1,1'b1, 8'd2,    1'b0,1'b0,1'b1, 4'd5},  // R5 N+1
        '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 8'd1,    1'b0,1'b0,1'b0, 4'd7},  // R7 clear
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 8'(N+1), 1'b0,1'b1,1'b0, 4'd8},  // R8 tie -> OV
        '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 8'(N+4), 1'b0,1'b1,1'b0, 4'd8},  // R8 UV never
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'd1,    1'b0,1'b0,1'b0, 4'd7}   // R7 clear
    };

    task automatic check3(input logic epg, input logic eov, input logic euv,
                          input int req, input string what);
        checks++;
        if (pg_ok !== epg || crowbar_req !== eov || tristate_req !== euv) begin
            errors++;
            $display("FAIL R%0d %s: pg/ov/uv actual=%b%b%b expected=%b%b%b",
                     req, what, pg_ok, crowbar_req, tristate_req, epg, eov, euv);
        end
    endtask

    task automatic drive(input vec_t v);
        chan_en = v.en; ss_done = v.ss; at_ninety = v.a90;
        over_hi = v.ovh; under_lo = v.unl; deep_under = v.deep;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check3(1'b0, 1'b0, 1'b0, 10, "reset state");          // R10
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            repeat (int'(VEC[i].hold)) @(posedge clk);
            @(negedge clk);
            check3(VEC[i].pg, VEC[i].ov, VEC[i].uv, int'(VEC[i].req),
                   $sformatf("vector %0d", i));
        end

        // Directed: reset while an overvoltage fault is latched (R10)
        chan_en = 1'b1; ss_done = 1'b1; at_ninety = 1'b1; over_hi = 1'b1;
        repeat (N + 1) @(posedge clk);
        @(negedge clk);
        check3(1'b0, 1'b1, 1'b0, 4, "latched before reset");
        rst_n = 1'b0;
        #1;
        check3(1'b0, 1'b0, 1'b0, 10, "async reset clears fault");
        over_hi = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Directed: good level held from reset release rises after exactly N edges (R1)
        repeat (N - 1) @(posedge clk);
        @(negedge clk);
        check3(1'b0, 1'b0, 1'b0, 1, "N-1 edges after reset");
        @(posedge clk);
        @(negedge clk);
        check3(1'b1, 1'b0, 1'b0, 1, "N edges after reset");

        // Directed: disabling drops pg at once (R7)
        chan_en = 1'b0;
        #1;
        check3(1'b0, 1'b0, 1'b0, 7, "pg follows enable");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule